// File: doc/BRIEF.md
# Exhaustive Key Search Driver

This block feeds a fully pipelined cipher key-testing engine and judges what comes back. While a search runs it places one fresh 128-bit candidate key on its key output in every clock cycle, counting upward from all zeros, and holds no bubbles between keys. The engine behind it returns a 64-bit result a fixed number of cycles later. That latency is a parameter. An internal alignment line carries every issued key for the same number of cycles, so each returning result meets the key that produced it. When a valid result equals the known ciphertext, the block raises a one-cycle hit and keeps the matching key in a held register.

Software or a sequencer starts the sweep, may pause and resume it, and may restart it from zero at any time. Once the all-ones key has gone out, issue stops. The block then waits long enough for the last result to be judged and raises done, which stays high until a restart. A restart also discards any results still in flight that belong to keys issued before it.

Top module: `ksd_top`

## Requirements
- R1: After reset, key_o is zero, key_vld_o, hit_o and done_o are low, and hit_key_o is zero.
- R2: A start pulse in the idle state begins issuing keys from the current counter value, which is zero after reset or restart. key_vld_o stays high on consecutive cycles, and each key is the previous key plus one, until the all-ones key has been issued.
- R3: A stop pulse while keys are issuing lets the key of that cycle go out and then drops key_vld_o. key_o then holds the next unissued key. A later start issues that key next, so no key is skipped or repeated.
- R4: When res_vld_i is high and res_i equals ct_i in both 32-bit halves (bits 63:32 and 31:0), hit_o is high for exactly the following cycle. This is LAT+1 cycles after the cycle in which the matching key was issued.
- R5: On a hit, hit_key_o shows the key issued LAT cycles before the matching result. It keeps that value until the next hit or a restart.
- R6: No hit is reported for a result whose res_vld_i is low, or whose aligned key slot holds no issued key, such as a key issued before a restart.
- R7: After the all-ones key is issued, key_vld_o stays low. done_o rises LAT+2 cycles after the cycle in which the all-ones key was issued, which is one cycle after that key's hit could appear. done_o then stays high, and start pulses have no effect.
- R8: restart_i is synchronous and wins over start, stop and a matching result in the same cycle. In the next cycle key_o is zero, and key_vld_o, hit_o and done_o are low, and hit_key_o is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin or resume key issue |
| stop_i | input | 1 | Pause key issue after the current key |
| restart_i | input | 1 | Synchronous clear of counter, hit and done |
| ct_i | input | RES_W (64) | Known ciphertext, held constant during a search |
| key_o | output | KEY_W (128) | Candidate key to the engine |
| key_vld_o | output | 1 | Candidate key is valid this cycle |
| res_i | input | RES_W (64) | Result from the engine |
| res_vld_i | input | 1 | Result is valid this cycle |
| hit_o | output | 1 | One-cycle match indication |
| hit_key_o | output | KEY_W (128) | Key that produced the latest match |
| done_o | output | 1 | Key space exhausted and pipeline drained |

## Verification
Two functions can fall in the same cycle: a restart and the arrival of a result that matches the ciphertext. The bench provokes this by targeting a key, counting LAT cycles from its issue, and raising restart exactly when the matching result is presented. It judges the outcome by requiring that hit_o stays low and that hit_key_o, key_o and done_o read cleared in the next cycle. A second case raises restart while a matching key is still inside the alignment line. This confirms that the stale result, which the engine model still delivers, is ignored.

// File: rtl/ksd_pkg.sv
package ksd_pkg;
  typedef enum logic [1:0] {
    S_IDLE  = 2'd0,
    S_RUN   = 2'd1,
    S_DRAIN = 2'd2,
    S_DONE  = 2'd3
  } ksd_state_e;
endpackage

// File: rtl/ksd_keygen.sv
module ksd_keygen
  import ksd_pkg::*;
#(
  parameter int KEY_W = 128,
  parameter int LAT   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic             start_i,
  input  logic             stop_i,
  output logic [KEY_W-1:0] key_o,
  output logic             key_vld_o,
  output logic             done_o
);
  localparam int DW = $clog2(LAT + 1);
  localparam logic [DW-1:0]    DRAIN_END = DW'(LAT);
  localparam logic [KEY_W-1:0] KEY_LAST  = {KEY_W{1'b1}};

  ksd_state_e       st_q;
  logic [KEY_W-1:0] key_q;
  logic             vld_q;
  logic [DW-1:0]    drain_q;
  logic             done_q;

  always_ff @(posedge clk) begin
    if (rst || restart_i) begin
      st_q    <= S_IDLE;
      key_q   <= '0;
      vld_q   <= 1'b0;
      drain_q <= '0;
      done_q  <= 1'b0;
    end else begin
      case (st_q)
        S_IDLE: begin
          if (start_i) begin
            st_q  <= S_RUN;
            vld_q <= 1'b1;
          end
        end
        S_RUN: begin
          if (key_q == KEY_LAST) begin
            st_q    <= S_DRAIN;
            vld_q   <= 1'b0;
            drain_q <= '0;
          end else begin
            key_q <= key_q + KEY_W'(1);
            if (stop_i) begin
              st_q  <= S_IDLE;
              vld_q <= 1'b0;
            end
          end
        end
        S_DRAIN: begin
          if (drain_q == DRAIN_END) begin
            st_q   <= S_DONE;
            done_q <= 1'b1;
          end else begin
            drain_q <= drain_q + DW'(1);
          end
        end
        default: ;
      endcase
    end
  end

  assign key_o     = key_q;
  assign key_vld_o = vld_q;
  assign done_o    = done_q;

  // R2: back-to-back valid keys step by one
  p_key_step_r2: assert property (@(posedge clk) disable iff (rst)
    (key_vld_o && $past(key_vld_o)) |-> (key_o == $past(key_o) + KEY_W'(1)));
  // R7: nothing is issued once done
  p_done_quiet_r7: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !key_vld_o);
  // R7: done holds until restart
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (rst)
    (done_o && !restart_i) |=> done_o);
  // R8: restart clears counter and done
  p_restart_clear_r8: assert property (@(posedge clk) disable iff (rst)
    restart_i |=> (key_o == '0 && !key_vld_o && !done_o));
endmodule

// File: rtl/ksd_align.sv
module ksd_align #(
  parameter int W   = 128,
  parameter int LAT = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clr_i,
  input  logic [W-1:0] d_i,
  input  logic         v_i,
  output logic [W-1:0] d_o,
  output logic         v_o
);
  logic [W-1:0] dat_q [LAT];
  logic         val_q [LAT];

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    if (g == 0) begin : g_head
      always_ff @(posedge clk) dat_q[0] <= d_i;
      always_ff @(posedge clk) begin
        if (rst || clr_i) val_q[0] <= 1'b0;
        else              val_q[0] <= v_i;
      end
    end else begin : g_body
      always_ff @(posedge clk) dat_q[g] <= dat_q[g-1];
      always_ff @(posedge clk) begin
        if (rst || clr_i) val_q[g] <= 1'b0;
        else              val_q[g] <= val_q[g-1];
      end
    end
  end

  assign d_o = dat_q[LAT-1];
  assign v_o = val_q[LAT-1];
endmodule

// File: rtl/ksd_match.sv
module ksd_match #(
  parameter int KEY_W = 128,
  parameter int RES_W = 64
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_i,
  input  logic [RES_W-1:0] res_i,
  input  logic             res_vld_i,
  input  logic [RES_W-1:0] ct_i,
  input  logic [KEY_W-1:0] key_i,
  input  logic             key_vld_i,
  output logic             hit_o,
  output logic [KEY_W-1:0] hit_key_o
);
  localparam int HW = RES_W / 2;

  logic [1:0]       half_eq;
  logic             hit_q;
  logic [KEY_W-1:0] hk_q;

  for (genvar h = 0; h < 2; h++) begin : g_half
    assign half_eq[h] = (res_i[h*HW +: HW] == ct_i[h*HW +: HW]);
  end

  always_ff @(posedge clk) begin
    if (rst || clr_i) begin
      hit_q <= 1'b0;
      hk_q  <= '0;
    end else begin
      hit_q <= 1'b0;
      if (res_vld_i && key_vld_i && (&half_eq)) begin
        hit_q <= 1'b1;
        hk_q  <= key_i;
      end
    end
  end

  assign hit_o     = hit_q;
  assign hit_key_o = hk_q;

  // R6: a hit needs a valid result and an occupied key slot
  p_hit_valid_r6: assert property (@(posedge clk) disable iff (rst)
    hit_o |-> $past(res_vld_i && key_vld_i));
  // R5: held key only changes on a hit or a clear
  p_key_held_r5: assert property (@(posedge clk) disable iff (rst)
    (!hit_o && !$past(clr_i)) |-> $stable(hit_key_o));
  // R8: clear wins over a coincident match
  p_restart_hit_r8: assert property (@(posedge clk) disable iff (rst)
    clr_i |=> (!hit_o && hit_key_o == '0));
endmodule

// File: rtl/ksd_top.sv
module ksd_top #(
  parameter int KEY_W = 128,
  parameter int RES_W = 64,
  parameter int LAT   = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic             stop_i,
  input  logic             restart_i,
  input  logic [RES_W-1:0] ct_i,
  output logic [KEY_W-1:0] key_o,
  output logic             key_vld_o,
  input  logic [RES_W-1:0] res_i,
  input  logic             res_vld_i,
  output logic             hit_o,
  output logic [KEY_W-1:0] hit_key_o,
  output logic             done_o
);
  logic [KEY_W-1:0] al_key;
  logic             al_vld;

  ksd_keygen #(.KEY_W(KEY_W), .LAT(LAT)) u_gen (
    .clk       (clk),
    .rst       (rst),
    .restart_i (restart_i),
    .start_i   (start_i),
    .stop_i    (stop_i),
    .key_o     (key_o),
    .key_vld_o (key_vld_o),
    .done_o    (done_o)
  );

  ksd_align #(.W(KEY_W), .LAT(LAT)) u_align (
    .clk   (clk),
    .rst   (rst),
    .clr_i (restart_i),
    .d_i   (key_o),
    .v_i   (key_vld_o),
    .d_o   (al_key),
    .v_o   (al_vld)
  );

  ksd_match #(.KEY_W(KEY_W), .RES_W(RES_W)) u_match (
    .clk       (clk),
    .rst       (rst),
    .clr_i     (restart_i),
    .res_i     (res_i),
    .res_vld_i (res_vld_i),
    .ct_i      (ct_i),
    .key_i     (al_key),
    .key_vld_i (al_vld),
    .hit_o     (hit_o),
    .hit_key_o (hit_key_o)
  );
endmodule

// File: tb/ksd_top_tb_top.sv
module ksd_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int KW  = 8;
  localparam int LAT = 4;
  localparam int NV  = 6;
  localparam logic [KW-1:0] TGT  [NV] = '{8'h00, 8'h01, 8'h5C, 8'h80, 8'hFE, 8'hFF};
  localparam int            EXPH [NV] = '{1, 1, 1, 1, 1, 0};

  logic          clk = 0, rst = 1, start_i = 0, stop_i = 0, restart_i = 0;
  logic [63:0]   ct_i = '0, res_i = '0;
  logic          res_vld_i = 0;
  logic [KW-1:0] key_o, hit_key_o;
  logic          key_vld_o, hit_o, done_o;

  int tests = 0, fails = 0, cyc = 0;
  logic          pv [LAT];
  logic [KW-1:0] pk [LAT];
  logic [KW-1:0] exp_next;
  int seq_err, nvld, nhits, hit_cyc, iss_cyc, last_cyc, done_cyc;
  logic [KW-1:0] hk, hk_done;
  logic [KW-1:0] watch_key;

  always #(CLK_PERIOD/2) clk = ~clk;

  ksd_top #(.KEY_W(KW), .RES_W(64), .LAT(LAT)) dut_i (
    .clk(clk), .rst(rst), .start_i(start_i), .stop_i(stop_i), .restart_i(restart_i),
    .ct_i(ct_i), .key_o(key_o), .key_vld_o(key_vld_o), .res_i(res_i),
    .res_vld_i(res_vld_i), .hit_o(hit_o), .hit_key_o(hit_key_o), .done_o(done_o)
  );

  function automatic logic [63:0] fn(input logic [KW-1:0] k);
    logic [31:0] w = {24'd0, k};
    return {w * 32'h9E3779B1, ~w ^ 32'h5A5A5A5A};
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clr_mon();
    seq_err = 0; nvld = 0; nhits = 0; hit_cyc = -1; iss_cyc = -1;
    last_cyc = -1; done_cyc = -1; hk = '0; hk_done = '0; exp_next = '0;
  endtask

  // one cycle: sample outputs mid-cycle, then drive the engine model
  task automatic tick();
    @(negedge clk);
    cyc++;
    if (key_vld_o) begin
      if (key_o !== exp_next) seq_err++;
      exp_next = key_o + 1'b1;
      nvld++;
      if (key_o == watch_key) iss_cyc = cyc;
      if (key_o == '1) last_cyc = cyc;
    end
    if (hit_o) begin nhits++; hk = hit_key_o; hit_cyc = cyc; end
    if (done_o && done_cyc < 0) begin done_cyc = cyc; hk_done = hit_key_o; end
    res_vld_i = pv[LAT-1];
    res_i     = pv[LAT-1] ? fn(pk[LAT-1]) : ct_i;  // invalid slots carry a matching value
    for (int i = LAT-1; i > 0; i--) begin pv[i] = pv[i-1]; pk[i] = pk[i-1]; end
    pv[0] = key_vld_o; pk[0] = key_o;
  endtask

  task automatic do_restart();
    restart_i = 1; tick(); restart_i = 0; clr_mon();
  endtask

  task automatic do_start();
    start_i = 1; tick(); start_i = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    for (int i = 0; i < LAT; i++) begin pv[i] = 0; pk[i] = '0; end
    watch_key = '0;
    clr_mon();
    repeat (3) @(posedge clk);
    @(negedge clk); rst = 0;
    tick();
    // R1: reset state
    chk("R1 key", key_o, 0);
    chk("R1 vld", key_vld_o, 0);
    chk("R1 hit", hit_o, 0);
    chk("R1 hit_key", hit_key_o, 0);
    chk("R1 done", done_o, 0);

    // vector table: full sweeps with one target each
    for (int v = 0; v < NV; v++) begin
      ct_i = (EXPH[v] != 0) ? fn(TGT[v]) : 64'h0;
      watch_key = TGT[v];
      do_restart();
      do_start();
      for (int n = 0; n < 400 && done_cyc < 0; n++) tick();
      chk("R2 sequence errors", seq_err, 0);
      chk("R2 keys issued", nvld, 256);
      chk("R4/R6 hit count", nhits, EXPH[v]);
      chk("R7 done delay", done_cyc - last_cyc, LAT + 2);
      if (EXPH[v] != 0) begin
        chk("R4 hit delay", hit_cyc - iss_cyc, LAT + 1);
        chk("R5 hit key", hk, TGT[v]);
        chk("R5 key held at done", hk_done, TGT[v]);
      end
    end

    // R7: start ignored once done
    do_start(); tick();
    chk("R7 no issue after done", key_vld_o, 0);
    chk("R7 done stays", done_o, 1);

    // R3: stop and resume
    ct_i = 64'h0; watch_key = '0;
    do_restart(); do_start();
    repeat (3) tick();
    stop_i = 1; tick(); stop_i = 0;
    begin
      logic [KW-1:0] pk_hold;
      int vhi;
      vhi = 0; pk_hold = key_o;
      repeat (4) begin tick(); if (key_vld_o) vhi++; if (key_o !== pk_hold) vhi++; end
      chk("R3 paused", vhi, 0);
      do_start();
      chk("R3 resumes at held key", key_o, pk_hold);
      chk("R3 resumed valid", key_vld_o, 1);
      repeat (5) tick();
      chk("R3 no skip or repeat", seq_err, 0);
    end

    // R8: restart in the same cycle as a matching result
    ct_i = fn(8'h03); watch_key = 8'h03;
    do_restart(); do_start();
    while (!(key_vld_o && key_o == 8'h03)) tick();
    repeat (LAT) tick();
    restart_i = 1; tick(); restart_i = 0;
    chk("R8 hit suppressed", hit_o, 0);
    chk("R8 hit key cleared", hit_key_o, 0);
    chk("R8 key cleared", key_o, 0);
    chk("R8 vld cleared", key_vld_o, 0);
    chk("R8 no hit seen", nhits, 0);

    // R6: stale in-flight key after restart is ignored
    ct_i = fn(8'h02); watch_key = 8'h02;
    do_restart(); do_start();
    while (!(key_vld_o && key_o == 8'h02)) tick();
    restart_i = 1; tick(); restart_i = 0;
    nhits = 0;
    repeat (LAT + 3) tick();
    chk("R6 stale result ignored", nhits, 0);
    chk("R6 hit key untouched", hit_key_o, 0);

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule